// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block sits between one processor load/store port and a single-ported word memory. It carries out indivisible read-modify-write operations on memory words. The requester sends an opcode, a word address, a source operand, a mask or compare operand and a bit index. For each atomic operation the block returns one response. The response carries the previous memory word when the operation defines one.

Ordinary stores are posted into a small write buffer. The buffer drains to memory whenever the memory port is free. An atomic request first waits until every earlier store has reached memory. It then reads the target word, computes the new value, writes it back and responds. No other memory access can take place between that read and that write.

A fixed permission table is indexed by the top address bits and supplies a read enable and a write enable for each region. An atomic operation needs both enables. When either is missing, the request is rejected with an error and memory is not touched.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: Opcode 0 is a posted store. It is queued in a buffer of `WB_DEPTH` (4) entries and written to memory in issue order. It produces no response. With the buffer full, `req_ready` is 0. A store to a region whose write enable is 0 is discarded.
- R3: Opcode 1 (masked insert) sets memory to `(old & ~mask) | (src & mask)` and responds with data 0.
- R4: Opcode 2 (swap) writes `src` to memory and returns the old word.
- R5: Opcode 3 (compare-and-swap) compares the old word with `req_mask`. On equality it writes `src`; otherwise memory is left unchanged. In both cases it returns the old word.
- R6: Opcode 4 (masked swap) sets memory to `(old & ~mask) | (src & mask)` and returns the complete old word.
- R7: Opcode 5 (bit store) writes `src[0]` into bit `req_bit` of the word, keeps every other bit and responds with data 0.
- R8: The region is `addr[AW-1 -: REGION_BITS]`. Bit r of `RD_MAP`/`WR_MAP` (defaults 4'b1011 / 4'b0111) enables region r. An atomic request to a region lacking either enable, and any request with opcode 6 or 7, gets a response with `rsp_err` 1 and data 0. Memory is left unchanged. `rsp_err` is never 1 without `rsp_valid`.
- R9: An atomic operation reads memory only after every store accepted before it has been written. It therefore sees those stores.
- R10: From acceptance of an atomic request until its response, `req_ready` is 0. The read and the write use consecutive memory accesses with no other access between them. `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_op | input | 3 | Opcode (0 store, 1 insert, 2 swap, 3 CAS, 4 masked swap, 5 bit store) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Source operand |
| req_mask | input | DW | Mask, or compare value for CAS |
| req_bit | input | $clog2(DW) | Bit index for bit store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Old word, or 0 |
| rsp_err | output | 1 | Protection or opcode fault |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory takes the access this cycle |
| mem_rdata | input | DW | Read data, valid the cycle after an accepted read |

## Verification
The operations are run on random words with random masks, and CAS is given both a matching and a non-matching compare value. This separates a missing write from a wrong merge, and the full-word return from the zero return. The memory grant is held low while stores are queued and then toggled at random. A store that is read back by the next atomic exposes any read that overtakes the buffer drain. Requests to the read-only region, the write-only region and undefined opcodes tell the permission fault apart from the opcode fault. Random addresses are kept within a few words so that operations collide often.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
   localparam logic [2:0] OP_STORE  = 3'd0;
   localparam logic [2:0] OP_INSERT = 3'd1;
   localparam logic [2:0] OP_SWAP   = 3'd2;
   localparam logic [2:0] OP_CAS    = 3'd3;
   localparam logic [2:0] OP_MSWAP  = 3'd4;
   localparam logic [2:0] OP_BITST  = 3'd5;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DRAIN   = 3'd1,
      ST_READ    = 3'd2,
      ST_MODIFY  = 3'd3,
      ST_WRITE   = 3'd4,
      ST_RESPOND = 3'd5
   } rmw_state_e;
endpackage

// File: rtl/atomic_rmw_perm.sv
module atomic_rmw_perm #(
   parameter int AW          = 10,
   parameter int REGION_BITS = 2,
   parameter logic [(1<<REGION_BITS)-1:0] RD_MAP = '1,
   parameter logic [(1<<REGION_BITS)-1:0] WR_MAP = '1
) (
   input  logic [AW-1:0] addr,
   output logic          rd_ok,
   output logic          wr_ok
);
   if (REGION_BITS < 0 || REGION_BITS > AW) begin : g_bad_region
      $error("atomic_rmw_perm: REGION_BITS out of range");
   end

   if (REGION_BITS == 0) begin : g_flat
      assign rd_ok = RD_MAP[0];
      assign wr_ok = WR_MAP[0];
   end else begin : g_table
      logic [REGION_BITS-1:0] region;
      assign region = addr[AW-1 -: REGION_BITS];
      assign rd_ok  = RD_MAP[region];
      assign wr_ok  = WR_MAP[region];
   end
endmodule

// File: rtl/atomic_rmw_wbuf.sv
module atomic_rmw_wbuf #(
   parameter int AW    = 10,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic          empty,
   output logic          full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("atomic_rmw_wbuf: DEPTH must be a power of two, at least 2");
   end

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW:0]   wp_q, rp_q;

   assign empty     = (wp_q == rp_q);
   assign full      = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
   assign head_addr = addr_q[rp_q[PW-1:0]];
   assign head_data = data_q[rp_q[PW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wp_q[PW-1:0]] <= push_addr;
         data_q[wp_q[PW-1:0]] <= push_data;
      end
   end

   AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R2
   AST_WB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R2
endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
   import atomic_rmw_pkg::*;
#(
   parameter int DW = 32,
   parameter int BW = $clog2(DW)
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] old_word,
   input  logic [DW-1:0] src,
   input  logic [DW-1:0] mask,
   input  logic [BW-1:0] bit_idx,
   output logic [DW-1:0] new_word,
   output logic          do_write,
   output logic [DW-1:0] ret_word
);
   logic [DW-1:0] merged;
   assign merged = (old_word & ~mask) | (src & mask);

   always_comb begin
      new_word = old_word;
      do_write = 1'b0;
      ret_word = '0;
      unique case (op)
         OP_INSERT: begin
            new_word = merged;
            do_write = 1'b1;
         end
         OP_SWAP: begin
            new_word = src;
            do_write = 1'b1;
            ret_word = old_word;
         end
         OP_CAS: begin
            ret_word = old_word;
            if (old_word == mask) begin
               new_word = src;
               do_write = 1'b1;
            end
         end
         OP_MSWAP: begin
            new_word = merged;
            do_write = 1'b1;
            ret_word = old_word;
         end
         OP_BITST: begin
            new_word[bit_idx] = src[0];
            do_write = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_rmw_pkg::*;
#(
   parameter int AW          = 10,
   parameter int DW          = 32,
   parameter int WB_DEPTH    = 4,
   parameter int REGION_BITS = 2,
   parameter logic [(1<<REGION_BITS)-1:0] RD_MAP = 4'b1011,
   parameter logic [(1<<REGION_BITS)-1:0] WR_MAP = 4'b0111,
   localparam int BW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] req_mask,
   input  logic [BW-1:0] req_bit,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_err,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ready,
   input  logic [DW-1:0] mem_rdata
);
   if (DW < 2 || (1 << BW) != DW) begin : g_bad_dw
      $error("atomic_rmw_unit: DW must be a power of two");
   end

   rmw_state_e    state_q;
   logic [2:0]    a_op_q;
   logic [AW-1:0] a_addr_q;
   logic [DW-1:0] a_src_q, a_mask_q, new_q, ret_q;
   logic [BW-1:0] a_bit_q;
   logic          wr_q, err_q;

   logic          rd_ok, wr_ok;
   logic          wb_push, wb_pop, wb_empty, wb_full;
   logic [AW-1:0] wb_addr;
   logic [DW-1:0] wb_data;
   logic [DW-1:0] alu_new, alu_ret;
   logic          alu_wr;
   logic          accept, is_store, op_known, fault;

   atomic_rmw_perm #(
      .AW(AW), .REGION_BITS(REGION_BITS), .RD_MAP(RD_MAP), .WR_MAP(WR_MAP)
   ) u_perm (
      .addr(req_addr), .rd_ok(rd_ok), .wr_ok(wr_ok)
   );

   atomic_rmw_wbuf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(wb_push), .push_addr(req_addr), .push_data(req_wdata),
      .pop(wb_pop), .head_addr(wb_addr), .head_data(wb_data),
      .empty(wb_empty), .full(wb_full)
   );

   atomic_rmw_alu #(.DW(DW), .BW(BW)) u_alu (
      .op(a_op_q), .old_word(mem_rdata), .src(a_src_q), .mask(a_mask_q),
      .bit_idx(a_bit_q), .new_word(alu_new), .do_write(alu_wr), .ret_word(alu_ret)
   );

   assign req_ready = (state_q == ST_IDLE) && !wb_full;
   assign accept    = req_valid && req_ready;
   assign is_store  = (req_op == OP_STORE);
   assign op_known  = (req_op <= OP_BITST);
   assign fault     = !op_known || !rd_ok || !wr_ok;
   assign wb_push   = accept && is_store && wr_ok;

   assign rsp_valid = (state_q == ST_RESPOND);
   assign rsp_err   = rsp_valid && err_q;
   assign rsp_rdata = rsp_valid ? ret_q : '0;

   // memory port: atomic read/write take precedence, buffer drains otherwise
   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = a_addr_q;
      mem_wdata = new_q;
      wb_pop    = 1'b0;
      if (state_q == ST_READ) begin
         mem_en = 1'b1;
      end else if (state_q == ST_WRITE && wr_q) begin
         mem_en = 1'b1;
         mem_we = 1'b1;
      end else if ((state_q == ST_IDLE || state_q == ST_DRAIN) && !wb_empty) begin
         mem_en    = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = wb_addr;
         mem_wdata = wb_data;
         wb_pop    = mem_ready;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         a_op_q   <= OP_STORE;
         a_addr_q <= '0;
         a_src_q  <= '0;
         a_mask_q <= '0;
         a_bit_q  <= '0;
         new_q    <= '0;
         ret_q    <= '0;
         wr_q     <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept && !is_store) begin
                  a_op_q   <= req_op;
                  a_addr_q <= req_addr;
                  a_src_q  <= req_wdata;
                  a_mask_q <= req_mask;
                  a_bit_q  <= req_bit;
                  ret_q    <= '0;
                  wr_q     <= 1'b0;
                  err_q    <= fault;
                  state_q  <= fault ? ST_RESPOND : ST_DRAIN;
               end
            end
            ST_DRAIN:  if (wb_empty)  state_q <= ST_READ;
            ST_READ:   if (mem_ready) state_q <= ST_MODIFY;
            ST_MODIFY: begin
               new_q   <= alu_new;
               wr_q    <= alu_wr;
               ret_q   <= alu_ret;
               state_q <= ST_WRITE;
            end
            ST_WRITE:  if (!wr_q || mem_ready) state_q <= ST_RESPOND;
            ST_RESPOND: state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> !req_ready); // R10
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
   AST_NO_ACCESS_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && (state_q == ST_MODIFY || state_q == ST_WRITE)) |-> (mem_we && mem_addr == a_addr_q)); // R10
   AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ) |-> wb_empty); // R9
   AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R8
   AST_FAULT_SKIPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !is_store && fault) |=> (rsp_err && !mem_en)); // R8
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
   localparam int AW = 10;
   localparam int DW = 32;
   localparam int BW = 5;
   localparam int NW = 1 << AW;
   localparam logic [3:0] RDM = 4'b1011;
   localparam logic [3:0] WRM = 4'b0111;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] req_mask = '0;
   logic [BW-1:0] req_bit = '0;
   logic          rsp_valid, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ready = 1'b1;
   logic [DW-1:0] mem_rdata = '0;

   logic [DW-1:0] bmem    [NW];
   logic [DW-1:0] ref_mem [NW];
   int checks = 0;
   int errors = 0;
   int mr_mode = 1;
   int cycles = 0;

   always #4 clk = ~clk;

   atomic_rmw_unit u_atomic_rmw_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .req_bit(req_bit),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] init_word(int i);
      return (i * 32'h9E3779B9) ^ 32'h5A5A0000;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) bmem[i] <= init_word(i);
      end else if (mem_en && mem_ready) begin
         if (mem_we) bmem[mem_addr] <= mem_wdata;
         else        mem_rdata <= bmem[mem_addr];
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (mr_mode == 0)      mem_ready = 1'b0;
         else if (mr_mode == 1) mem_ready = 1'b1;
         else                   mem_ready = ($urandom % 4) != 0;
      end
   end

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit region_ok(logic [AW-1:0] a, bit wr);
      return wr ? WRM[a[AW-1 -: 2]] : RDM[a[AW-1 -: 2]];
   endfunction

   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd0; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (region_ok(a, 1'b1)) ref_mem[a] = d;
   endtask

   task automatic do_atomic(input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] s, input logic [DW-1:0] m,
                            input logic [BW-1:0] b, input string req);
      logic [DW-1:0] old, nw, ret;
      bit            err, wr, busy_ok;
      int            n;
      old = ref_mem[a]; nw = old; ret = '0; wr = 1'b0;
      err = (op > 3'd5) || !region_ok(a, 1'b0) || !region_ok(a, 1'b1);
      if (!err) begin
         case (op)
            3'd1: begin nw = (old & ~m) | (s & m); wr = 1'b1; end
            3'd2: begin nw = s; wr = 1'b1; ret = old; end
            3'd3: begin ret = old; if (old == m) begin nw = s; wr = 1'b1; end end
            3'd4: begin nw = (old & ~m) | (s & m); wr = 1'b1; ret = old; end
            3'd5: begin nw[b] = s[0]; wr = 1'b1; end
            default: ;
         endcase
      end
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = s; req_mask = m; req_bit = b;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy_ok = 1'b1; n = 0;
      while (!rsp_valid && n < 200) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      if (req_ready) busy_ok = 1'b0;
      check(rsp_valid, {req, " R10 response arrives"}, 32'(rsp_valid), 32'd1);
      check(rsp_rdata == ret, {req, " data"}, rsp_rdata, ret);
      check(rsp_err == err, {req, " R8 error flag"}, 32'(rsp_err), 32'(err));
      check(busy_ok, {req, " R10 ready low while busy"}, 32'(busy_ok), 32'd1);
      @(negedge clk);
      check(!rsp_valid, {req, " R10 single-cycle response"}, 32'(rsp_valid), 32'd0);
      if (wr && !err) ref_mem[a] = nw;
      if (err) check(bmem[a] == ref_mem[a], {req, " R8 memory unchanged"}, bmem[a], ref_mem[a]);
   endtask

   initial begin
      while (cycles < 150000) @(negedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] a;
      logic [DW-1:0] s, m;
      int            r, mism;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NW; i++) ref_mem[i] = init_word(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
      check(mem_en == 1'b0, "R1 memory idle after reset", 32'(mem_en), 32'd0);

      // fill the buffer while memory is stalled
      mr_mode = 0;
      for (int k = 0; k < 4; k++) do_store(10'h010 + 10'(k), 32'hA000_0000 + 32'(k));
      check(req_ready == 1'b0, "R2 ready low with buffer full", 32'(req_ready), 32'd0);
      check(bmem[10'h010] == init_word(16), "R2 nothing written while stalled",
            bmem[10'h010], init_word(16));
      mr_mode = 1;
      // swap sees last buffered store
      do_atomic(3'd2, 10'h013, 32'h1234_5678, '0, '0, "R9 swap after drain");
      check(bmem[10'h010] == 32'hA000_0000, "R2 first store in order", bmem[10'h010], 32'hA000_0000);

      do_atomic(3'd1, 10'h020, 32'hFFFF_0000, 32'h0F0F_F0F0, '0, "R3 masked insert");
      do_atomic(3'd2, 10'h021, 32'hCAFE_BABE, '0, '0, "R4 swap");
      do_atomic(3'd3, 10'h021, 32'h1111_2222, 32'hCAFE_BABE, '0, "R5 CAS match");
      do_atomic(3'd3, 10'h021, 32'h3333_4444, 32'h0BAD_F00D, '0, "R5 CAS mismatch");
      do_atomic(3'd2, 10'h021, 32'h0, '0, '0, "R5 CAS result read back");
      do_atomic(3'd4, 10'h022, 32'h00FF_00FF, 32'hF0F0_0F0F, '0, "R6 masked swap");
      do_atomic(3'd5, 10'h023, 32'h1, '0, 5'd31, "R7 bit store high bit");
      do_atomic(3'd5, 10'h023, 32'h0, '0, 5'd0, "R7 bit store low bit");
      do_atomic(3'd2, 10'h200, 32'h5555_5555, '0, '0, "R8 no read permission");
      do_atomic(3'd2, 10'h300, 32'h6666_6666, '0, '0, "R8 no write permission");
      do_atomic(3'd6, 10'h024, 32'h7777_7777, '0, '0, "R8 undefined opcode");
      do_store(10'h301, 32'hDEAD_BEEF);
      repeat (10) @(negedge clk);
      check(bmem[10'h301] == init_word(10'h301), "R2 store to unwritable region dropped",
            bmem[10'h301], init_word(10'h301));

      mr_mode = 2;
      for (int k = 0; k < 400; k++) begin
         r = $urandom % 10;
         a = (($urandom % 8) < 6) ? {2'(($urandom % 2)), 8'(($urandom % 8))}
                                  : {2'(2 + ($urandom % 2)), 8'(($urandom % 8))};
         s = $urandom; m = $urandom;
         if (r < 3) do_store(a, s);
         else begin
            if (r == 4 && ($urandom % 2) == 0) m = ref_mem[a];
            do_atomic(3'(1 + (r - 3)), a, s, m, 5'($urandom % 32), "R3-R7 random op");
         end
      end

      mr_mode = 1;
      repeat (20) @(negedge clk);
      mism = 0;
      for (int i = 0; i < NW; i++) if (bmem[i] !== ref_mem[i]) mism++;
      check(mism == 0, "R2 R9 final memory image", 32'(mism), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule